// File: doc/BRIEF.md
# Operand Fetch and Address Unit

This block takes one 32-bit instruction word of a word-addressed processor and produces the operand value that the execute stage needs. It splits the word into its fields and sign-extends the 16-bit numeric field. When an index register is named, it adds that register's contents, which it reads through a register-file read port. When the word is marked indirect, it makes exactly one memory read at the resulting address through a request/valid interface.

Together with the value, the block returns the opcode and main register. It also classifies the operand as a write destination. The operand is a legal destination if it is an indirect memory word. It is also legal if it is a bare index register, meaning the indirect bit is clear and the numeric field is zero. Every other form is reported as illegal, so the execute stage can raise an execution failure.

Top module: `opnd_unit`

## Requirements
- R1: Fields are taken from the word as opcode = bits 31:25, indirect flag = bit 24, main register = bits 23:20, index register = bits 19:16, numeric = bits 15:0. They are presented on `op_opcode`, `op_ind` and `op_main` while `operand_valid` is high.
- R2: The numeric field is two's complement (-32768 to +32767) and is sign-extended to 32 bits before any addition.
- R3: An index field of 0 selects no register, so nothing is added and register 0 never acts as an index.
- R4: For a nonzero index field, the total is the sign-extended numeric field plus the 32-bit contents of that register, modulo 2^32.
- R5: For a direct word (bit 24 = 0), `operand_value` equals the total. `operand_valid` is high for exactly one cycle, in the cycle after the word is accepted, and no memory request is made.
- R6: For an indirect word (bit 24 = 1), exactly one read is issued with `mem_addr` equal to the total. `mem_req` and `mem_addr` hold steady until `mem_rvalid` is seen. `operand_valid` rises in the next cycle with `operand_value` equal to `mem_rdata`.
- R7: `op_dest_ok` is 1 when bit 24 is set, or when bit 24 is clear with a nonzero index field and a zero numeric field. It is 0 otherwise.
- R8: `op_dest_reg` is 1 exactly when the operand is the bare-register destination form, meaning bit 24 clear, a nonzero index and a zero numeric field.
- R9: `instr_ready` is high only while no memory read is outstanding. Direct words can therefore be accepted on consecutive cycles, giving one `operand_valid` pulse per word in order.
- R10: A synchronous active-high reset leaves `instr_ready` = 1, `operand_valid` = 0 and `mem_req` = 0.
- R11: The word 0x0725FE89 yields opcode 3, indirect 1, main register 2, and a memory read at index register 5's contents minus 375.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Block idle; the word is taken at this edge |
| rf_addr | output | 4 | Register-file read address (index field) |
| rf_data | input | 32 | Register-file read data, combinational |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read word address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| operand_valid | output | 1 | One-cycle pulse, result ready |
| operand_value | output | 32 | Operand value |
| op_opcode | output | 7 | Opcode field |
| op_ind | output | 1 | Indirect flag |
| op_main | output | 4 | Main register field |
| op_dest_ok | output | 1 | Operand is a legal destination |
| op_dest_reg | output | 1 | Destination is a bare register |

## Verification
The result pulse for one word and the acceptance of the next word can fall in the same cycle. This happens for every direct word, and also for the word that follows an indirect read. The bench provokes it by holding `instr_valid` high across a run of direct words and by issuing words immediately after indirect ones. The memory latency is varied between zero and two wait cycles. Each pulse is judged against a queue of expected results that is filled at acceptance. A pulse that is dropped, duplicated or out of order therefore shows up as a value mismatch or as a count mismatch at the end.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 7;
  localparam int REG_W  = 4;
  localparam int NUM_W  = 16;

  localparam int NUM_LSB = 0;
  localparam int IDX_LSB = NUM_LSB + NUM_W;
  localparam int MAIN_LSB = IDX_LSB + REG_W;
  localparam int IND_BIT = MAIN_LSB + REG_W;
  localparam int OPC_LSB = IND_BIT + 1;

  typedef struct packed {
    logic [OPC_W-1:0] opcode;
    logic             ind;
    logic [REG_W-1:0] main_reg;
    logic [REG_W-1:0] idx_reg;
    logic [NUM_W-1:0] num;
  } instr_fields_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MEM  = 1'b1
  } ctrl_state_t;
endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]   word,
  output instr_fields_t  fields,
  output logic           dest_ok,
  output logic           dest_reg
);
  logic idx_named;
  logic num_zero;

  always_comb begin
    fields.num      = word[NUM_LSB  +: NUM_W];
    fields.idx_reg  = word[IDX_LSB  +: REG_W];
    fields.main_reg = word[MAIN_LSB +: REG_W];
    fields.ind      = word[IND_BIT];
    fields.opcode   = word[OPC_LSB  +: OPC_W];
    idx_named = (fields.idx_reg != '0);
    num_zero  = (fields.num == '0);
    dest_reg  = !fields.ind && idx_named && num_zero;
    dest_ok   = fields.ind || dest_reg;
  end
endmodule

// File: rtl/opnd_addr.sv
module opnd_addr
  import opnd_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = NUM_W,
  parameter int R = REG_W
) (
  input  logic [N-1:0] num,
  input  logic [R-1:0] idx_reg,
  input  logic [W-1:0] rf_data,
  output logic [W-1:0] total
);
  localparam int EXT = W - N;
  logic [W-1:0] num_ext;
  logic [W-1:0] idx_term;

  always_comb begin
    num_ext  = {{EXT{num[N-1]}}, num};
    idx_term = (idx_reg != '0) ? rf_data : '0;
    total    = num_ext + idx_term;
  end
endmodule

// File: rtl/opnd_ctrl.sv
module opnd_ctrl
  import opnd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  instr_fields_t fields,
  input  logic          dest_ok,
  input  logic          dest_reg,
  input  logic [W-1:0]  total,
  output logic          instr_ready,
  output logic          mem_req,
  output logic [W-1:0]  mem_addr,
  input  logic          mem_rvalid,
  input  logic [W-1:0]  mem_rdata,
  output logic          operand_valid,
  output logic [W-1:0]  operand_value,
  output logic [OPC_W-1:0] op_opcode,
  output logic          op_ind,
  output logic [REG_W-1:0] op_main,
  output logic          op_dest_ok,
  output logic          op_dest_reg
);
  ctrl_state_t state;
  logic        take;

  assign instr_ready = (state == ST_IDLE);
  assign take        = instr_ready && instr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      mem_req       <= 1'b0;
      mem_addr      <= '0;
      operand_valid <= 1'b0;
      operand_value <= '0;
      op_opcode     <= '0;
      op_ind        <= 1'b0;
      op_main       <= '0;
      op_dest_ok    <= 1'b0;
      op_dest_reg   <= 1'b0;
    end else begin
      operand_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            op_opcode   <= fields.opcode;
            op_ind      <= fields.ind;
            op_main     <= fields.main_reg;
            op_dest_ok  <= dest_ok;
            op_dest_reg <= dest_reg;
            if (fields.ind) begin
              state    <= ST_MEM;
              mem_req  <= 1'b1;
              mem_addr <= total;
            end else begin
              operand_valid <= 1'b1;
              operand_value <= total;
            end
          end
        end
        ST_MEM: begin
          if (mem_rvalid) begin
            state         <= ST_IDLE;
            mem_req       <= 1'b0;
            operand_valid <= 1'b1;
            operand_value <= mem_rdata;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_unit.sv
module opnd_unit
  import opnd_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [W-1:0]     instr_word,
  output logic             instr_ready,
  output logic [REG_W-1:0] rf_addr,
  input  logic [W-1:0]     rf_data,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  input  logic             mem_rvalid,
  input  logic [W-1:0]     mem_rdata,
  output logic             operand_valid,
  output logic [W-1:0]     operand_value,
  output logic [OPC_W-1:0] op_opcode,
  output logic             op_ind,
  output logic [REG_W-1:0] op_main,
  output logic             op_dest_ok,
  output logic             op_dest_reg
);
  instr_fields_t fields;
  logic          dest_ok;
  logic          dest_reg;
  logic [W-1:0]  total;

  assign rf_addr = fields.idx_reg;

  opnd_decode #(.W(W)) i_decode (
    .word     (instr_word),
    .fields   (fields),
    .dest_ok  (dest_ok),
    .dest_reg (dest_reg)
  );

  opnd_addr #(.W(W), .N(NUM_W), .R(REG_W)) i_addr (
    .num     (fields.num),
    .idx_reg (fields.idx_reg),
    .rf_data (rf_data),
    .total   (total)
  );

  opnd_ctrl #(.W(W)) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .fields        (fields),
    .dest_ok       (dest_ok),
    .dest_reg      (dest_reg),
    .total         (total),
    .instr_ready   (instr_ready),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .operand_valid (operand_valid),
    .operand_value (operand_value),
    .op_opcode     (op_opcode),
    .op_ind        (op_ind),
    .op_main       (op_main),
    .op_dest_ok    (op_dest_ok),
    .op_dest_reg   (op_dest_reg)
  );
endmodule

// File: rtl/opnd_unit_chk.sv
module opnd_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         instr_valid,
  input logic [W-1:0] instr_word,
  input logic         instr_ready,
  input logic         mem_req,
  input logic [W-1:0] mem_addr,
  input logic         mem_rvalid,
  input logic         operand_valid,
  input logic         op_ind,
  input logic         op_dest_ok,
  input logic         op_dest_reg
);
  // R5: a direct word gives its result in the next cycle without a read
  a_r5_direct_next: assert property (@(posedge clk) disable iff (rst)
    instr_valid && instr_ready && !instr_word[24] |=> operand_valid && !mem_req);

  // R6: the request holds with a fixed address until served
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  // R6: a served read yields the result next and drops the request
  a_r6_result_after_read: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_rvalid |=> operand_valid && !mem_req);

  // R9: no new word is taken while a read is outstanding
  a_r9_busy_when_reading: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !instr_ready);

  // R7: an indirect operand is always a legal destination
  a_r7_indirect_dest: assert property (@(posedge clk) disable iff (rst)
    operand_valid && op_ind |-> op_dest_ok);

  // R8: the bare-register form is a legal, direct destination
  a_r8_reg_form: assert property (@(posedge clk) disable iff (rst)
    operand_valid && op_dest_reg |-> op_dest_ok && !op_ind);

  // R10: the cycle after reset is idle
  a_r10_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> instr_ready && !operand_valid && !mem_req);
endmodule

bind opnd_unit opnd_unit_chk #(.W(W)) i_chk (
  .clk           (clk),
  .rst           (rst),
  .instr_valid   (instr_valid),
  .instr_word    (instr_word),
  .instr_ready   (instr_ready),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .operand_valid (operand_valid),
  .op_ind        (op_ind),
  .op_dest_ok    (op_dest_ok),
  .op_dest_reg   (op_dest_reg)
);

// File: tb/test_opnd_unit.sv
module test_opnd_unit;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        instr_ready;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        operand_valid;
  logic [31:0] operand_value;
  logic [6:0]  op_opcode;
  logic        op_ind;
  logic [3:0]  op_main;
  logic        op_dest_ok;
  logic        op_dest_reg;

  int compared = 0;
  int mismatched = 0;
  int wr = 0;
  int rd = 0;
  int reads = 0;
  int ind_issued = 0;
  int lat = 0;
  int wcnt = 0;
  logic [31:0] cur_addr = '0;
  logic        done = 1'b0;

  logic [31:0] e_val [DEPTH];
  logic [6:0]  e_opc [DEPTH];
  logic        e_ind [DEPTH];
  logic [3:0]  e_main[DEPTH];
  logic        e_dok [DEPTH];
  logic        e_dreg[DEPTH];

  always #4 clk = ~clk;

  function automatic logic [31:0] reg_val(input logic [3:0] a);
    if (a == 4'd0) return 32'hDEAD_0000;
    return 32'h0001_0000 * a + 32'h37 * a + 32'h7FFF_FF00 * a[3];
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return ~a ^ 32'h5A5A_1234;
  endfunction

  assign rf_data    = reg_val(rf_addr);
  assign mem_rdata  = mem_val(mem_addr);
  assign mem_rvalid = mem_req && (wcnt == lat);

  always @(posedge clk) begin
    if (rst || !mem_req || mem_rvalid) wcnt <= 0;
    else wcnt <= wcnt + 1;
    if (!rst && mem_req && mem_rvalid) reads <= reads + 1;
  end

  opnd_unit i_opnd_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .instr_ready(instr_ready), .rf_addr(rf_addr), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .operand_valid(operand_valid),
    .operand_value(operand_value), .op_opcode(op_opcode), .op_ind(op_ind),
    .op_main(op_main), .op_dest_ok(op_dest_ok), .op_dest_reg(op_dest_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Result monitor: judges each pulse against the queue, checks request address
  always @(negedge clk) begin
    if (!rst && operand_valid) begin
      if (rd >= wr) check("R9 extra pulse", 32'(rd), 32'(wr - 1));
      else begin
        check("R5/R6 value", operand_value, e_val[rd]);
        check("R1 opcode", 32'(op_opcode), 32'(e_opc[rd]));
        check("R1 ind", 32'(op_ind), 32'(e_ind[rd]));
        check("R1 main", 32'(op_main), 32'(e_main[rd]));
        check("R7 dest_ok", 32'(op_dest_ok), 32'(e_dok[rd]));
        check("R8 dest_reg", 32'(op_dest_reg), 32'(e_dreg[rd]));
        rd <= rd + 1;
      end
    end
    if (!rst && mem_req) check("R6 mem_addr", mem_addr, cur_addr);
  end

  // Offer a word; it is taken at the next edge once ready is seen at a falling edge
  task automatic send(input logic [31:0] w, input bit hold);
    logic [31:0] num_ext;
    logic [31:0] total;
    logic        ind;
    logic [3:0]  idx;
    instr_word  = w;
    instr_valid = 1'b1;
    while (!instr_ready) @(negedge clk);
    ind = w[24];
    idx = w[19:16];
    num_ext = {{16{w[15]}}, w[15:0]};                   // R2
    total = num_ext + ((idx != 0) ? reg_val(idx) : 0);  // R3, R4
    e_val[wr]  = ind ? mem_val(total) : total;
    e_opc[wr]  = w[31:25];
    e_ind[wr]  = ind;
    e_main[wr] = w[23:20];
    e_dreg[wr] = !ind && idx != 0 && w[15:0] == 0;
    e_dok[wr]  = ind || e_dreg[wr];
    if (ind) begin
      cur_addr = total;
      lat = wr % 3;
      ind_issued++;
    end
    wr++;
    @(negedge clk);
    if (!hold) instr_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (rd < wr && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    check("R9 results drained", 32'(rd), 32'(wr));
  endtask

  initial begin
    logic [15:0] nums [6];
    nums[0] = 16'd0; nums[1] = 16'd1; nums[2] = 16'hFFFF;
    nums[3] = 16'h8000; nums[4] = 16'h7FFF; nums[5] = 16'hFE89;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: idle after reset
    check("R10 ready", 32'(instr_ready), 32'd1);
    check("R10 valid", 32'(operand_valid), 32'd0);
    check("R10 req", 32'(mem_req), 32'd0);

    // R11: the worked encoding
    send(32'h0725FE89, 1'b0);
    drain();
    check("R11 read address", cur_addr, reg_val(4'd5) - 32'd375);

    // R1-style sweep: every index, both indirect settings, boundary numerics
    for (int i = 0; i < 2; i++) begin
      for (int x = 0; x < 16; x++) begin
        for (int n = 0; n < 6; n++) begin
          send({7'(x * 5 + n), i[0], 4'(15 - x), 4'(x), nums[n]}, 1'b0);
          drain();
        end
      end
    end

    // R9: back-to-back direct words, valid held high
    for (int k = 0; k < 8; k++) send({7'(k), 1'b0, 4'(k), 4'(k), 16'(k * 1000 - 3000)}, 1'b1);
    instr_valid = 1'b0;
    drain();

    // R6, R9: indirect immediately followed by direct words
    for (int k = 0; k < 6; k++) send({7'd9, 1'(k % 2), 4'd1, 4'(k + 10), 16'(k * 7)}, 1'b1);
    instr_valid = 1'b0;
    drain();

    check("R6 one read per indirect word", 32'(reads), 32'(ind_issued));
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule